// File: doc/BRIEF.md
# Prescaled 8-bit Down-Counting Interval Timer

The block holds an 8-bit counter that software loads over a small register bus. Once enabled, the counter steps down by one on every selected prescaler output. A 7-stage binary prescaler sits in front of the counter, and a 3-bit select field picks a division ratio from 1 to 128 of the incoming tick enable. When the count arrives at zero, a sticky flag is raised. The counter then keeps going, wrapping past zero to 0xFF, so software can read it and see how many steps have passed since the flag went up.

The flag drives an interrupt request only while the interrupt enable bit is set. With the enable clear, software can poll the flag as a status bit. The only way to clear the flag is a separate write-only clear bit. Writing a new count also discards a pending flag. Both registers can be read at any time, and reading has no side effect.

Top module: `tick_timer8`

## Requirements
- R1: After reset, both registers read 0x00 and `irq` is low.
- R2: Each counter step lowers the count by one, and a count of 0x00 steps to 0xFF. Counting continues after zero.
- R3: The flag (control register bit 7) is set in the cycle in which the count steps from 0x01 to 0x00. Loading 0x00 does not set it.
- R4: With select value n (control register bits 2..0), the counter steps once every 2^n enabled ticks. A counter load restarts the prescaler, so the first step comes on the 2^n-th tick after the load.
- R5: While the enable bit (control bit 4) is 0, ticks change neither the prescaler nor the count. Setting the bit again resumes from the held count.
- R6: Writing the control register with bit 6 set clears the flag. Writing with bit 6 clear leaves the flag as it is, and so does writing bit 7 with any value.
- R7: Writing the counter register loads the written value and clears a pending flag.
- R8: `irq` is high exactly when the flag is set and the interrupt enable (control bit 5) is 1.
- R9: The control register reads {flag, 0, irq enable, enable, 0, select}. Bit 6 and bit 3 always read 0, and an address that is not decoded reads 0x00.
- R10: Read data is combinational from the addressed register. Any number of reads leaves the count unchanged.
- R11: If a step to zero and a flag-clear write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| tick | input | 1 | Count source enable, one pulse per tick |
| irq | output | 1 | Interrupt request |

## Verification
Every register write and every counter step takes effect at the first rising edge that samples the strobe. Because read data is combinational, the result of a write or tick can be read back one edge later. The bench drives all inputs just after a falling edge and samples read data one time unit after setting the address, before the next rising edge. A burst of k ticks therefore spans exactly k rising edges. The expected count is the load value minus floor(k / 2^n), taken modulo 256. The flag and `irq` are checked after the same edge as the count.

// File: rtl/tick_timer8.sv
module tick_timer8 #(
  parameter int ADDR_W   = 2,
  parameter int CSR_ADDR = 0,
  parameter int CNT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              tick,
  output logic              irq
);
  localparam int SEL_W = 3;
  localparam int PS_W  = (1 << SEL_W) - 1;

  logic [7:0]       cnt_q;
  logic [PS_W-1:0]  ps_q;
  logic [PS_W-1:0]  ps_mask;
  logic [SEL_W-1:0] sel_q;
  logic             flag_q, ie_q, en_q;

  wire csr_wr = wr_en && (addr == ADDR_W'(CSR_ADDR));
  wire cnt_wr = wr_en && (addr == ADDR_W'(CNT_ADDR));
  wire run    = en_q && tick;

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign ps_mask[i] = (sel_q > SEL_W'(i));
  end

  wire step    = run && ((ps_q & ps_mask) == ps_mask);
  wire hit0    = step && !cnt_wr && (cnt_q == 8'd1);
  wire clr_req = csr_wr && wr_data[6];

  logic unused_wbits;
  assign unused_wbits = ^{wr_data[7], wr_data[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else if (cnt_wr) begin
      ps_q <= '0;
    end else if (run) begin
      ps_q <= ps_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= wr_data;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (csr_wr) begin
      ie_q  <= wr_data[5];
      en_q  <= wr_data[4];
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit0) begin
      flag_q <= 1'b1;
    end else if (clr_req || cnt_wr) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == ADDR_W'(CSR_ADDR)) begin
      rd_data = {flag_q, 1'b0, ie_q, en_q, 1'b0, sel_q};
    end else if (addr == ADDR_W'(CNT_ADDR)) begin
      rd_data = cnt_q;
    end
  end

  assign irq = flag_q & ie_q;
endmodule

module tick_timer8_chk #(
  parameter int ADDR_W   = 2,
  parameter int CNT_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              tick,
  input logic              irq,
  input logic [7:0]        cnt_q,
  input logic              flag_q,
  input logic              ie_q,
  input logic              en_q,
  input logic [2:0]        sel_q
);
  wire load = wr_en && (addr == ADDR_W'(CNT_ADDR));

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load) |=> $stable(cnt_q));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && sel_q == 3'd0 && !load) |=> (cnt_q == $past(cnt_q) - 8'd1));

  assert_flag_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == 8'd0));

  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!flag_q && cnt_q == $past(wr_data)));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q && flag_q));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !load && !(wr_en && addr != ADDR_W'(CNT_ADDR) && wr_data[6])) |=> flag_q);
endmodule

bind tick_timer8 tick_timer8_chk #(.ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .tick(tick), .irq(irq), .cnt_q(cnt_q), .flag_q(flag_q), .ie_q(ie_q),
  .en_q(en_q), .sel_q(sel_q)
);

// File: tb/tick_timer8_test.sv
module tick_timer8_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [1:0] A_CSR = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_NONE = 2'd3;

  localparam int VSEL [NV] = '{0, 0, 0, 1, 2, 3, 7, 7, 0, 4};
  localparam int VLD  [NV] = '{5, 3, 2, 10, 4, 2, 1, 1, 0, 128};
  localparam int VTK  [NV] = '{3, 3, 4, 6, 7, 16, 127, 128, 1, 40};
  localparam int VCNT [NV] = '{2, 0, 254, 7, 3, 0, 1, 0, 255, 126};
  localparam int VFLG [NV] = '{0, 1, 1, 0, 0, 1, 0, 1, 0, 0};

  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;
  int nchk = 0, nbad = 0;
  logic [7:0] v;

  tick_timer8 uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                   .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(A_CSR, v); check("R1 csr", v, 0);
    rd(A_CNT, v); check("R1 cnt", v, 0);
    check("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      wr(A_CSR, 8'h10 | 8'(VSEL[k]));
      wr(A_CNT, 8'(VLD[k]));
      ticks(VTK[k]);
      rd(A_CNT, v); check("R2/R4 count", v, VCNT[k]);
      rd(A_CSR, v); check("R3 flag", int'(v[7]), VFLG[k]);
    end

    // R5 enable off holds count, resume
    wr(A_CSR, 8'h00);
    wr(A_CNT, 8'd10);
    ticks(5);
    rd(A_CNT, v); check("R5 held", v, 10);
    wr(A_CSR, 8'h10);
    ticks(2);
    rd(A_CNT, v); check("R5 resume", v, 8);

    // R8 polled flag, irq gating
    wr(A_CNT, 8'd1);
    ticks(1);
    rd(A_CSR, v); check("R3 flag set", int'(v[7]), 1);
    check("R8 irq masked", irq, 0);
    wr(A_CSR, 8'h90);
    rd(A_CSR, v); check("R6 bit7 write ignored", int'(v[7]), 1);
    wr(A_CSR, 8'h30);
    check("R8 irq high", irq, 1);
    rd(A_CSR, v); check("R6 bit6 zero keeps flag", int'(v[7]), 1);
    wr(A_CSR, 8'h70);
    rd(A_CSR, v); check("R6 clear", int'(v[7]), 0);
    check("R8 irq low", irq, 0);

    // R7 counter write drops pending flag
    wr(A_CNT, 8'd1);
    ticks(1);
    check("R7 irq pending", irq, 1);
    wr(A_CNT, 8'd5);
    rd(A_CSR, v); check("R7 flag dropped", int'(v[7]), 0);
    check("R7 irq dropped", irq, 0);
    rd(A_CNT, v); check("R7 loaded", v, 5);

    // R9 layout
    wr(A_CSR, 8'hFF);
    rd(A_CSR, v); check("R9 layout", v, 8'h37);
    rd(A_NONE, v); check("R9 undecoded", v, 0);

    // R10 reads leave count alone
    wr(A_CSR, 8'h00);
    wr(A_CNT, 8'h42);
    for (int i = 0; i < 6; i++) begin
      rd(A_CSR, v); rd(A_CNT, v);
      @(negedge clk);
    end
    rd(A_CNT, v); check("R10 stable", v, 8'h42);

    // R11 step to zero with same-cycle clear
    wr(A_CSR, 8'h10);
    wr(A_CNT, 8'd1);
    tick = 1; addr = A_CSR; wr_data = 8'h50; wr_en = 1;
    @(negedge clk);
    tick = 0; wr_en = 0;
    rd(A_CSR, v); check("R11 set wins", int'(v[7]), 1);
    rd(A_CNT, v); check("R11 count", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule